// File: doc/BRIEF.md
# Tracking Converter Up/Down Code Counter

This block is the digital heart of a servo-style analog-to-digital converter. It holds a code that feeds an external DAC. A comparator outside the block reports every cycle whether the DAC output lies below the analog input. On each clock the block moves the code one step toward the input. The code itself is the conversion result. It is always visible at the output, and no separate register holds it.

There is no start or done handshake. After a large jump in the input, the code closes the gap at one LSB per clock. Under a steady input it dithers between two adjacent codes. The tracking rate depends only on the clock applied to the block. The code stops at zero and at all-ones instead of wrapping. An enable input freezes it, and a synchronous reset loads midscale.

Each cycle a small decision stage picks one of three moves. HOLD is chosen when enable is low, or when the code is at a limit and the comparator pushes past it. UP is chosen when the comparator reports the DAC output below the input and the code is below all-ones. DOWN is chosen when the comparator reports the DAC output at or above the input and the code is above zero. The counter register applies the chosen move on the next edge. Reset overrides all three moves and loads midscale.

Top module: `track_adc_core`

## Requirements
- R1: When `rst` is high at a rising edge, `code_out` becomes midscale, 2^(WIDTH-1) (128 for WIDTH=8), after that edge.
- R2: With `enable` high and `dac_below` high (1 = DAC output below the input), a code below all-ones increases by exactly one at the next edge.
- R3: With `enable` high and `dac_below` low (DAC output at or above the input), a code above zero decreases by exactly one at the next edge.
- R4: Outside reset, `code_out` never differs by more than one from its value on the previous edge, and it never wraps between zero and all-ones.
- R5: At all-ones with `enable` high and `dac_below` high, the code stays at all-ones.
- R6: At zero with `enable` high and `dac_below` low, the code stays at zero.
- R7: With `enable` low and `rst` low, `code_out` holds its value whatever `dac_below` shows.
- R8: Suppose the comparator reports `dac_below` = (code < T) for a constant input code T with 0 < T <= all-ones. Once the code has reached T, it alternates on every edge between T-1 and T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tracking step per rising edge |
| rst | input | 1 | Synchronous active-high reset to midscale |
| enable | input | 1 | High to track, low to freeze the code |
| dac_below | input | 1 | Comparator result: 1 when the DAC output is below the analog input |
| code_out | output | WIDTH | Current DAC code and conversion result |

## Verification
The bench drives a slow ramp from midscale up to a steady input and checks the one-LSB dither there. A wrong comparator sense would run the code away instead of settling on two codes. It pushes the input beyond full scale and then to zero, which forces long saturated stretches. A counter without saturation would wrap from 255 to 0, or from 0 to 255, and both the step-size check and the scoreboard would report the jump. While enable is low, the bench swings the comparator both ways to show that the code stays frozen. A reset in the middle of a run must return the code to 128 rather than to zero.

// File: rtl/trk_pkg.sv
package trk_pkg;
    // One-cycle move chosen for the code register
    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2
    } move_t;
endpackage

// File: rtl/step_select.sv
module step_select
    import trk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             enable,
    input  logic             dac_below,
    input  logic [WIDTH-1:0] code,
    output move_t            move
);
    localparam logic [WIDTH-1:0] CODE_TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CODE_BOT = {WIDTH{1'b0}};

    logic at_top;
    logic at_bot;

    assign at_top = (code == CODE_TOP);
    assign at_bot = (code == CODE_BOT);

    always_comb begin
        move = MOVE_HOLD;
        unique case ({enable, dac_below})
            2'b11:   move = at_top ? MOVE_HOLD : MOVE_UP;
            2'b10:   move = at_bot ? MOVE_HOLD : MOVE_DOWN;
            default: move = MOVE_HOLD;
        endcase
    end
endmodule

// File: rtl/code_counter.sv
module code_counter
    import trk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  move_t            move,
    output logic [WIDTH-1:0] code
);
    localparam logic [WIDTH-1:0] CODE_MID = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= CODE_MID;
        end else begin
            unique case (move)
                MOVE_UP:   code <= code + ONE;
                MOVE_DOWN: code <= code - ONE;
                default:   code <= code;
            endcase
        end
    end

    // R1: first cycle after reset shows midscale
    assert_reset_mid_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> code == CODE_MID);

    // R4: never more than one LSB per clock, no wrap
    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
            (({1'b0, code} == {1'b0, $past(code)})) ||
            (({1'b0, code} == {1'b0, $past(code)} + {1'b0, ONE})) ||
            (({1'b0, $past(code)} == {1'b0, code} + {1'b0, ONE})));
endmodule

// File: rtl/track_adc_core.sv
module track_adc_core
    import trk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             dac_below,
    output logic [WIDTH-1:0] code_out
);
    localparam logic [WIDTH-1:0] CODE_TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CODE_BOT = {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    move_t move;

    step_select #(.WIDTH(WIDTH)) u_sel (
        .enable    (enable),
        .dac_below (dac_below),
        .code      (code_out),
        .move      (move)
    );

    code_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .move (move),
        .code (code_out)
    );

    // R2: count up when the DAC output is below the input
    assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
        enable && dac_below && code_out != CODE_TOP |=> code_out == $past(code_out) + ONE);

    // R3: count down when the DAC output is at or above the input
    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        enable && !dac_below && code_out != CODE_BOT |=> code_out == $past(code_out) - ONE);

    // R5: clamp at all-ones
    assert_clamp_top_R5: assert property (@(posedge clk) disable iff (rst)
        enable && dac_below && code_out == CODE_TOP |=> code_out == CODE_TOP);

    // R6: clamp at zero
    assert_clamp_bot_R6: assert property (@(posedge clk) disable iff (rst)
        enable && !dac_below && code_out == CODE_BOT |=> code_out == CODE_BOT);

    // R7: frozen while disabled
    assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(code_out));
endmodule

// File: tb/sim_track_adc_core.sv
module sim_track_adc_core;
    localparam int W    = 8;
    localparam int MAXV = 255;
    localparam int MIDV = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enable = 1'b0;
    logic         dac_below = 1'b0;
    logic [W-1:0] code_out;

    always #4 clk = ~clk;

    track_adc_core #(.WIDTH(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .dac_below (dac_below),
        .code_out  (code_out)
    );

    typedef struct {
        int    val;
        string tag;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    fails  = 0;
    int    target = MIDV;
    int    mcode  = MIDV;
    int    prev_code = 0;
    bit    prev_ok = 1'b0;
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected code
    task automatic drive(input bit r, input bit en, input bit flip = 1'b0);
        item_t it;
        bit    cmp;
        @(negedge clk);
        cmp = (mcode < target) ^ flip;
        rst = r;
        enable = en;
        dac_below = cmp;
        if (r) begin
            it.val = MIDV; it.tag = "R1";
        end else if (!en) begin
            it.val = mcode; it.tag = "R7";
        end else if (cmp) begin
            if (mcode == MAXV) begin it.val = MAXV; it.tag = "R5"; end
            else begin it.val = mcode + 1; it.tag = "R2"; end
        end else begin
            if (mcode == 0) begin it.val = 0; it.tag = "R6"; end
            else begin it.val = mcode - 1; it.tag = "R3"; end
        end
        mcode = it.val;
        sbq.push_back(it);
    endtask

    // Monitor: compare each result one step after the edge that made it
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(int'(code_out) == it.val, it.tag, int'(code_out), it.val);
            if (it.tag != "R1" && prev_ok) begin
                int d;
                d = int'(code_out) - prev_code;
                check(d >= -1 && d <= 1, "R4", int'(code_out), prev_code);
            end
            prev_code = int'(code_out);
            prev_ok = 1'b1;
        end
    end

    // R8: with a steady input, the code alternates between T-1 and T
    task automatic dither_check(input int t);
        int last;
        last = -1;
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, 1'b1);
            @(posedge clk);
            #2;
            check(int'(code_out) == t || int'(code_out) == t - 1, "R8", int'(code_out), t);
            if (last >= 0)
                check(int'(code_out) != last, "R8", int'(code_out), (last == t) ? t - 1 : t);
            last = int'(code_out);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset to midscale
        target = MIDV;
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        // R2: ramp up toward 200, then R8 dither
        target = 200;
        for (int i = 0; i < 80; i++) drive(1'b0, 1'b1);
        dither_check(200);
        // R7: frozen while the comparator swings both ways
        for (int i = 0; i < 12; i++) drive(1'b0, 1'b0, i[0]);
        // R5: input beyond full scale
        target = MAXV + 1;
        for (int i = 0; i < 70; i++) drive(1'b0, 1'b1);
        // R3, R6, R4: fall all the way to zero and sit there
        target = 0;
        for (int i = 0; i < 270; i++) drive(1'b0, 1'b1);
        // R1: reset during a run, then track a low input
        drive(1'b1, 1'b1);
        target = 60;
        for (int i = 0; i < 80; i++) drive(1'b0, 1'b1);
        dither_check(60);
        // R7: disabled with the comparator forced both ways at a low code
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, i[1]);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule